// File: doc/BRIEF.md
# Two-Bank Burst Memory Read Model

This block models a small read-only banked memory whose core array runs slower than its data port. Each bank holds a fixed number of rows, and each row is several port-widths wide. A read request names a bank, a row and a column. The bank spends a fixed number of port cycles on the core access. It then latches a whole row segment of N port words into a buffer and shifts that buffer out over N consecutive port cycles. N is the ratio between the port rate and the core rate.

Every access is a full burst, even when the requester only wants one word. The word that was asked for is marked as useful, and the other words of the burst travel on the port marked as discarded. A single bank leaves the port idle during every core access. With two banks, the core access of one bank overlaps the burst of the other. Requests that alternate between the banks therefore keep the port busy on every cycle, as long as the access delay does not exceed the burst length.

The array contents come from a fixed arithmetic pattern, so every word on the port can be predicted.

Top module: `ibm_interleaved_mem`

## Requirements
- R1: While reset is held, and in the cycles after it is released, `out_valid` is low and `req_ready` is high for every bank.
- R2: The cell at bank b, row r, column c holds (37*b + 13*r + 5*c + r*c + PSEED) mod 2^DW.
- R3: A bank's first beat appears no earlier than LAT+1 cycles after the cycle in which its request handshake completes. When the port is idle and no other request is pending, the first beat appears exactly LAT+1 cycles after that cycle.
- R4: Each accepted request produces exactly N consecutive cycles of `out_valid`, with no gap inside the burst.
- R5: Within a burst, `out_useful` is high only on beat number (col mod N), counting from 0, and is low on the other N-1 beats.
- R6: A bank accepts a request when it is idle or in the last cycle of its own burst, and stalls it (`req_ready` low) otherwise. A stalled request to one bank waits exactly LAT+N-1 cycles when it is presented on the cycle after that bank's own handshake. A request to an idle bank is accepted in the cycle it is presented.
- R7: Bursts leave the port in the order their requests were accepted, and never overlap. `out_bank` carries the bank number of the current beat.
- R8: If requests to a single bank are presented back to back, exactly LAT idle port cycles separate consecutive bursts.
- R9: If back-to-back requests alternate between the two banks, and LAT <= N, there are no idle port cycles between consecutive bursts.
- R10: Column c selects row segment c div N. Beat i of the burst carries the word at column (c div N)*N + i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port-rate clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| req_valid | input | 1 | A read request is presented |
| req_ready | output | 1 | The addressed bank can take the request this cycle |
| req_bank | input | $clog2(NBANK) | Target bank |
| req_row | input | $clog2(ROWS) | Row within the bank |
| req_col | input | $clog2(N*SEGS) | Column in port words; selects the segment and the useful beat |
| out_valid | output | 1 | A burst beat is on the port |
| out_data | output | DW | Beat data |
| out_useful | output | 1 | This beat is the requested word |
| out_bank | output | $clog2(NBANK) | Bank that owns the current beat |

## Verification
Some checks run on every cycle. They confirm that at most one bank drives the port at a time and that a burst, once started, runs its full length without a hole. They also confirm that no bank starts a burst before its access delay has elapsed, that the order queue never overflows, and that requests are only taken by a bank that is free. Other properties depend on a request stream rather than on a single cycle, so only the bench's scenarios show them. These are the exact idle gap of LAT cycles for single-bank streams, the gap-free port under alternating banks, and the exact stall length on a busy bank. The same holds for the in-order delivery of the predicted data and useful flags.

// File: rtl/ibm_pkg.sv
package ibm_pkg;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_ACCESS = 2'd1,
    BK_READY  = 2'd2,
    BK_BURST  = 2'd3
  } bank_state_t;

  // Contents of the read-only core array; the caller truncates to its word width.
  function automatic int cell_pattern(input int bank, input int row, input int col,
                                      input int seed);
    return bank * 37 + row * 13 + col * 5 + row * col + seed;
  endfunction

endpackage

// File: rtl/ibm_order.sv
module ibm_order #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned IDW   = 1,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push_i,
  input  logic [IDW-1:0] id_i,
  input  logic           pop_i,
  output logic [IDW-1:0] head_o,
  output logic           hv_o
);

  logic [IDW-1:0]  slot_q [DEPTH];
  logic [PW-1:0]   rd_q, rd_d, wr_q, wr_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head_o = slot_q[rd_q];
  assign hv_o   = (cnt_q != '0);

  always_comb begin
    rd_d  = pop_i  ? wrap_inc(rd_q) : rd_q;
    wr_d  = push_i ? wrap_inc(wr_q) : wr_q;
    cnt_d = cnt_q + CNTW'(push_i) - CNTW'(pop_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
      if (push_i) slot_q[wr_q] <= id_i;
    end
  end

  // R7: the order queue never takes more entries than it holds
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> ((cnt_q < CNTW'(DEPTH)) || pop_i));

  // R7: a burst only starts for a queued request
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> hv_o);

endmodule

// File: rtl/ibm_bank.sv
module ibm_bank
  import ibm_pkg::*;
#(
  parameter int unsigned DW      = 2,
  parameter int unsigned N       = 4,
  parameter int unsigned SEGS    = 2,
  parameter int unsigned ROWS    = 8,
  parameter int unsigned LAT     = 4,
  parameter int unsigned BANK_ID = 0,
  parameter int unsigned PSEED   = 5,
  localparam int unsigned COLS   = N * SEGS,
  localparam int unsigned RW     = $clog2(ROWS),
  localparam int unsigned CW     = $clog2(COLS),
  localparam int unsigned IW     = $clog2(N),
  localparam int unsigned SW     = $clog2(SEGS),
  localparam int unsigned LW     = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic [RW-1:0] row_i,
  input  logic [CW-1:0] col_i,
  input  logic          go_i,
  output logic          free_o,
  output logic          rdy_o,
  output logic          burst_o,
  output logic          last_o,
  output logic [DW-1:0] data_o,
  output logic          useful_o
);

  bank_state_t     st_q, st_d;
  logic [LW-1:0]   cnt_q, cnt_d;
  logic [RW-1:0]   row_q;
  logic [SW-1:0]   seg_q;
  logic [IW-1:0]   want_q, beat_q, beat_d;
  logic [N*DW-1:0] buf_q, buf_d, seg_word;
  logic            fetch_done, cnt_en, buf_en, beat_en;

  assign fetch_done = (st_q == BK_ACCESS) && (cnt_q == '0);
  assign burst_o    = (st_q == BK_BURST);
  assign last_o     = burst_o && (beat_q == IW'(N - 1));
  assign free_o     = (st_q == BK_IDLE) || last_o;
  assign rdy_o      = fetch_done || (st_q == BK_READY);
  assign data_o     = buf_q[DW-1:0];
  assign useful_o   = burst_o && (beat_q == want_q);

  // Row segment read from the core array: word i sits at column seg*N + i.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      seg_word[i*DW +: DW] = DW'(cell_pattern(int'(BANK_ID), int'(row_q),
                                              int'(seg_q) * int'(N) + i, int'(PSEED)));
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BK_IDLE:   if (accept_i) st_d = BK_ACCESS;
      BK_ACCESS: if (cnt_q == '0) st_d = go_i ? BK_BURST : BK_READY;
      BK_READY:  if (go_i) st_d = BK_BURST;
      BK_BURST:  if (last_o) st_d = accept_i ? BK_ACCESS : BK_IDLE;
      default:   st_d = BK_IDLE;
    endcase
  end

  always_comb begin
    cnt_en  = accept_i || ((st_q == BK_ACCESS) && (cnt_q != '0));
    cnt_d   = accept_i ? LW'(LAT - 1) : cnt_q - 1'b1;
    buf_en  = fetch_done || burst_o;
    buf_d   = fetch_done ? seg_word : (buf_q >> DW);
    beat_en = go_i || burst_o;
    beat_d  = go_i ? '0 : beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= BK_IDLE;
      cnt_q  <= '0;
      row_q  <= '0;
      seg_q  <= '0;
      want_q <= '0;
      beat_q <= '0;
      buf_q  <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en)  cnt_q  <= cnt_d;
      if (buf_en)  buf_q  <= buf_d;
      if (beat_en) beat_q <= beat_d;
      if (accept_i) begin
        row_q  <= row_i;
        seg_q  <= col_i[IW +: SW];
        want_q <= col_i[IW-1:0];
      end
    end
  end

  // Checker-only age counter: cycles since the last accepted request, saturating.
  logic [LW-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   age_q <= '0;
    else if (accept_i)            age_q <= '0;
    else if (age_q != LW'(LAT))   age_q <= age_q + 1'b1;
  end

  // R3: no beat leaves before the core access delay has elapsed
  assert_first_beat_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_o) |-> (age_q >= LW'(LAT)));

  // R4: a burst that has not reached its last beat keeps going
  assert_burst_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_o && !last_o) |=> burst_o);

  // R4: the last beat ends the burst
  assert_burst_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !burst_o);

  // R6: a request is only taken when the bank is free
  assert_accept_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |-> free_o);

endmodule

// File: rtl/ibm_interleaved_mem.sv
module ibm_interleaved_mem
  import ibm_pkg::*;
#(
  parameter int unsigned DW    = 2,
  parameter int unsigned N     = 4,
  parameter int unsigned SEGS  = 2,
  parameter int unsigned ROWS  = 8,
  parameter int unsigned LAT   = 4,
  parameter int unsigned NBANK = 2,
  parameter int unsigned PSEED = 5,
  localparam int unsigned COLS = N * SEGS,
  localparam int unsigned RW   = $clog2(ROWS),
  localparam int unsigned CW   = $clog2(COLS),
  localparam int unsigned BW   = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [BW-1:0] req_bank,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_useful,
  output logic [BW-1:0] out_bank
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  logic [NBANK-1:0] acc, go, free, rdy, burst, last, useful;
  logic [DW-1:0]    data [NBANK];
  logic [BW-1:0]    head;
  logic             hv, push, port_free;

  assign req_ready = (int'(req_bank) < int'(NBANK)) && free[req_bank];
  assign push      = req_valid && req_ready;
  assign port_free = !(|burst) || (|last);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign acc[b] = push && (req_bank == BW'(b));
    assign go[b]  = hv && (head == BW'(b)) && rdy[b] && port_free;

    ibm_bank #(
      .DW(DW), .N(N), .SEGS(SEGS), .ROWS(ROWS), .LAT(LAT),
      .BANK_ID(b), .PSEED(PSEED)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_i),
      .accept_i (acc[b]),
      .row_i    (req_row),
      .col_i    (req_col),
      .go_i     (go[b]),
      .free_o   (free[b]),
      .rdy_o    (rdy[b]),
      .burst_o  (burst[b]),
      .last_o   (last[b]),
      .data_o   (data[b]),
      .useful_o (useful[b])
    );
  end

  ibm_order #(.DEPTH(NBANK), .IDW(BW)) u_order (
    .clk    (clk),
    .rst_n  (rst_i),
    .push_i (push),
    .id_i   (req_bank),
    .pop_i  (|go),
    .head_o (head),
    .hv_o   (hv)
  );

  always_comb begin
    out_valid  = |burst;
    out_data   = '0;
    out_useful = 1'b0;
    out_bank   = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (burst[b]) begin
        out_data   = data[b];
        out_useful = useful[b];
        out_bank   = BW'(b);
      end
    end
  end

  // R7: the port has at most one owner
  assert_single_owner_R7: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(burst));

  // R7: at most one bank is granted the port per cycle
  assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(go));

endmodule

// File: tb/sim_ibm_interleaved_mem.sv
module sim_ibm_interleaved_mem;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 2, N = 4, SEGS = 2, ROWS = 8, LAT = 4, NBANK = 2, PSEED = 5;
  localparam int RW = $clog2(ROWS), CW = $clog2(N * SEGS), BW = $clog2(NBANK);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [BW-1:0] req_bank;
  logic [RW-1:0] req_row;
  logic [CW-1:0] req_col;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic          out_useful;
  logic [BW-1:0] out_bank;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ibm_interleaved_mem #(
    .DW(DW), .N(N), .SEGS(SEGS), .ROWS(ROWS), .LAT(LAT), .NBANK(NBANK), .PSEED(PSEED)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .out_valid(out_valid), .out_data(out_data), .out_useful(out_useful), .out_bank(out_bank)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int eq_b [1024], eq_d [1024], eq_u [1024];
  int q_wr = 0, q_rd = 0;
  int acc_cyc [256], first_cyc [256], gap_a [256];
  int n_acc = 0, n_burst = 0, idle_run = 0, pos;
  bit done = 1'b0;

  function automatic int exp_cell(input int b, input int r, input int c);
    return (b * 37 + r * 13 + c * 5 + r * c + PSEED) % (1 << DW);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Monitor: mid-cycle sampling of the port and of the handshake about to complete.
  always @(negedge clk) begin
    cyc++;
    if (out_valid) begin
      if (q_rd == q_wr) chk(1'b0, "R4 beat with no pending request", 1, 0);
      else begin
        pos = q_rd % N;
        if (pos == 0) begin
          gap_a[n_burst]     = idle_run;
          first_cyc[n_burst] = cyc;
          chk(cyc >= acc_cyc[n_burst] + LAT + 1, "R3 first beat too early",
              cyc, acc_cyc[n_burst] + LAT + 1);
          n_burst++;
        end
        chk(int'(out_bank) == eq_b[q_rd], "R7 beat bank/order", int'(out_bank), eq_b[q_rd]);
        chk(int'(out_data) == eq_d[q_rd], "R2 R10 beat data", int'(out_data), eq_d[q_rd]);
        chk(int'(out_useful) == eq_u[q_rd], "R5 useful flag", int'(out_useful), eq_u[q_rd]);
        q_rd++;
      end
      idle_run = 0;
    end else begin
      if (q_rd % N != 0) chk(1'b0, "R4 burst interrupted", 0, 1);
      idle_run++;
    end
    if (req_valid && req_ready) begin
      for (int i = 0; i < N; i++) begin
        eq_b[q_wr] = int'(req_bank);
        eq_d[q_wr] = exp_cell(int'(req_bank), int'(req_row), (int'(req_col) / N) * N + i);
        eq_u[q_wr] = (i == int'(req_col) % N) ? 1 : 0;
        q_wr++;
      end
      acc_cyc[n_acc] = cyc;
      n_acc++;
    end
  end

  // Called at posedge+1; returns at posedge+1 after the handshake.
  task automatic issue(input int b, input int r, input int c, output int stall);
    stall     = 0;
    req_valid = 1'b1;
    req_bank  = BW'(b);
    req_row   = RW'(r);
    req_col   = CW'(c);
    @(negedge clk);
    while (!req_ready) begin
      stall++;
      @(negedge clk);
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_drain();
    while (q_rd != q_wr) @(negedge clk);
    repeat (LAT + 3) @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  initial begin
    int s, base, rnd;
    rnd       = $urandom(32'd4242);
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_bank  = '0;
    req_row   = '0;
    req_col   = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(req_ready == 1'b1, "R1 bank0 ready after reset", int'(req_ready), 1);
    req_bank = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1 bank1 ready after reset", int'(req_ready), 1);
    @(posedge clk);
    #1;

    // Isolated request: exact latency, segment 1, useful beat 1.
    base = n_acc;
    issue(0, 3, 5, s);
    chk(s == 0, "R6 idle bank accepted at once", s, 0);
    wait_drain();
    chk(first_cyc[base] == acc_cyc[base] + LAT + 1, "R3 exact latency",
        first_cyc[base] - acc_cyc[base], LAT + 1);

    // Single-bank stream: stall length and idle gaps.
    base = n_acc;
    issue(0, 1, 0, s);
    issue(0, 2, 7, s);
    chk(s == LAT + N - 1, "R6 stall on busy bank", s, LAT + N - 1);
    issue(0, 4, 2, s);
    issue(0, 7, 3, s);
    wait_drain();
    for (int k = 1; k < 4; k++)
      chk(gap_a[base + k] == LAT, "R8 single-bank idle gap", gap_a[base + k], LAT);

    // Alternating banks: no idle cycles after the first burst.
    base = n_acc;
    issue(0, 0, 1, s);
    issue(1, 5, 6, s);
    chk(s == 0, "R6 other bank accepted during burst", s, 0);
    for (int k = 2; k < 8; k++) issue(k % 2, (k * 3) % ROWS, (k * 5) % (N * SEGS), s);
    wait_drain();
    for (int k = 1; k < 8; k++)
      chk(gap_a[base + k] == 0, "R9 alternating idle gap", gap_a[base + k], 0);

    // Random traffic.
    for (int k = 0; k < 80; k++) begin
      issue(int'($urandom_range(NBANK - 1)), int'($urandom_range(ROWS - 1)),
            int'($urandom_range(N * SEGS - 1)), s);
      repeat (int'($urandom_range(2))) begin
        @(posedge clk);
        #1;
      end
    end
    wait_drain();
    chk(q_rd == q_wr, "R4 every beat delivered", q_rd, q_wr);
    chk(n_burst == n_acc, "R4 one burst per request", n_burst, n_acc);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R4 watchdog expired", cyc, 0);
      finish_run();
    end
  end

endmodule